// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block sits behind a pair of adjacent byte-wide I/O ports and gives a host indirect access to a configuration register space. One port (select 0) holds an index; the other (select 1) is the data window onto whichever register the index names. The whole space stays closed until the host writes a fixed unlock byte to the index port on two consecutive index writes. A separate byte written to the index port closes it again.

Index values below a forwarding boundary are handled by this block. They hold a logical-device select register and read-only identification bytes: a 16-bit device ID, a revision byte and a 16-bit vendor ID, each word stored high byte first. Index values at or above the boundary are forwarded. The block presents the current index, the selected logical-device number and single-cycle data-port read and write strobes to downstream register files, and returns their read byte on the data port. It also raises a decoded flag when the general-purpose I/O device (number 0x06) is selected.

The host bus is a plain strobe interface: one cycle of `bus_wr` or `bus_rd` is one access. It has no back-pressure, so there is no valid/ready pair. Read data is combinational and valid in the cycle that `bus_rd` is high.

Top module: `cfg_access_port`

## Requirements
- R1: After reset the port is closed (`cfg_open`=0), `cur_index` is 0x00, `ldev_num` is 0x00 and `ld_gpio_sel` is 0.
- R2: Two index-port writes (`bus_sel`=0) of 0x87 in a row open the port; `cfg_open` goes high on the clock edge that takes the second write.
- R3: While closed, an index write of any value other than 0x87 after one 0x87 restarts the key sequence; a third 0x87 alone does not open the port.
- R4: While open, an index write of 0xAA closes the port without changing `cur_index`.
- R5: While closed, reads of either port return 0xFF. Data writes change nothing and raise no strobe. Index writes other than the key leave `cur_index` unchanged.
- R6: While open, an index write loads `cur_index`, and an index-port read returns it.
- R7: While open, a data write with the index at 0x07 loads `ldev_num`; a data read there returns it; `ld_gpio_sel` is 1 exactly when `ldev_num` is 0x06.
- R8: While open, data reads at index 0x20, 0x21, 0x22, 0x23 and 0x24 return the device ID high byte, the device ID low byte, the revision byte, the vendor ID high byte (0x19) and the vendor ID low byte (0x34).
- R9: While open with the index at or above 0x30, a data write raises `ld_wr_stb` and a data read raises `ld_rd_stb`, in the same cycle as the bus strobe, and the read returns `ld_rdata`. Unused indices below 0x30 read 0x00 and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_sel | input | 1 | Port select: 0 index, 1 data |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte (combinational) |
| cfg_open | output | 1 | Configuration space unlocked |
| cur_index | output | 8 | Current index register |
| ldev_num | output | 8 | Selected logical-device number |
| ld_gpio_sel | output | 1 | General-purpose I/O device selected |
| ld_wr_stb | output | 1 | Forwarded data-port write strobe |
| ld_rd_stb | output | 1 | Forwarded data-port read strobe |
| ld_rdata | input | 8 | Read byte from the downstream register file |

## Verification
A wrong key-sequence state shows on the very next data-port read: a closed port returns 0xFF, while an open port returns a register value. So a premature or missed unlock is visible one access after the offending index write. A corrupted index or device number shows on the next read of the index port or of index 0x07. It also shows at once on `cur_index`, `ldev_num` and `ld_gpio_sel`, since all three are driven straight from their registers. A wrong forwarding decision shows in the same cycle as the bus strobe, as a missing or extra `ld_wr_stb`/`ld_rd_stb` pulse.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t KEY_OPEN  = 8'h87;
  localparam byte_t KEY_CLOSE = 8'hAA;

  localparam byte_t IDX_LDSEL  = 8'h07;
  localparam byte_t IDX_DEV_HI = 8'h20;
  localparam byte_t IDX_DEV_LO = 8'h21;
  localparam byte_t IDX_REV    = 8'h22;
  localparam byte_t IDX_VND_HI = 8'h23;
  localparam byte_t IDX_VND_LO = 8'h24;
  localparam byte_t IDX_FWD    = 8'h30;

  localparam byte_t LDN_GPIO   = 8'h06;
  localparam byte_t CLOSED_RD  = 8'hFF;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } key_st_e;
endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
  import cfgp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idx_wr,
  input  byte_t wdata,
  output logic  open_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      unique case (st_q)
        ST_LOCKED: if (wdata == KEY_OPEN) st_d = ST_HALF;
        ST_HALF:   st_d = (wdata == KEY_OPEN) ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   if (wdata == KEY_CLOSE) st_d = ST_LOCKED;
        default:   st_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_LOCKED;
    else        st_q <= st_d;
  end

  assign open_o = (st_q == ST_OPEN);
endmodule

// File: rtl/cfgp_glob_regs.sv
module cfgp_glob_regs
  import cfgp_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0A5C,
  parameter logic [7:0]  DEV_REV = 8'h03,
  parameter logic [15:0] VND_ID  = 16'h1934
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  open_i,
  input  logic  wr_i,
  input  logic  rd_i,
  input  logic  sel_i,
  input  byte_t wdata_i,
  input  byte_t ld_rdata_i,
  output byte_t rdata_o,
  output byte_t index_o,
  output byte_t ldev_o,
  output logic  ld_wr_o,
  output logic  ld_rd_o
);
  byte_t index_q, ldev_q, local_rd;
  logic  fwd;

  assign fwd = (index_q >= IDX_FWD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      ldev_q  <= '0;
    end else if (open_i && wr_i) begin
      if (!sel_i && wdata_i != KEY_CLOSE) index_q <= wdata_i;
      if (sel_i && index_q == IDX_LDSEL)  ldev_q  <= wdata_i;
    end
  end

  always_comb begin
    unique case (index_q)
      IDX_LDSEL:  local_rd = ldev_q;
      IDX_DEV_HI: local_rd = DEV_ID[15:8];
      IDX_DEV_LO: local_rd = DEV_ID[7:0];
      IDX_REV:    local_rd = DEV_REV;
      IDX_VND_HI: local_rd = VND_ID[15:8];
      IDX_VND_LO: local_rd = VND_ID[7:0];
      default:    local_rd = '0;
    endcase
  end

  always_comb begin
    if (!open_i)     rdata_o = CLOSED_RD;
    else if (!sel_i) rdata_o = index_q;
    else if (fwd)    rdata_o = ld_rdata_i;
    else             rdata_o = local_rd;
  end

  assign ld_wr_o = open_i & wr_i & sel_i & fwd;
  assign ld_rd_o = open_i & rd_i & sel_i & fwd;
  assign index_o = index_q;
  assign ldev_o  = ldev_q;
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfgp_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0A5C,
  parameter logic [7:0]  DEV_REV = 8'h03,
  parameter logic [15:0] VND_ID  = 16'h1934
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cfg_open,
  output logic [7:0] cur_index,
  output logic [7:0] ldev_num,
  output logic       ld_gpio_sel,
  output logic       ld_wr_stb,
  output logic       ld_rd_stb,
  input  logic [7:0] ld_rdata
);
  logic open_w;

  cfgp_key_fsm u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (bus_wr & ~bus_sel),
    .wdata  (bus_wdata),
    .open_o (open_w)
  );

  cfgp_glob_regs #(
    .DEV_ID  (DEV_ID),
    .DEV_REV (DEV_REV),
    .VND_ID  (VND_ID)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_i     (open_w),
    .wr_i       (bus_wr),
    .rd_i       (bus_rd),
    .sel_i      (bus_sel),
    .wdata_i    (bus_wdata),
    .ld_rdata_i (ld_rdata),
    .rdata_o    (bus_rdata),
    .index_o    (cur_index),
    .ldev_o     (ldev_num),
    .ld_wr_o    (ld_wr_stb),
    .ld_rd_o    (ld_rd_stb)
  );

  assign cfg_open    = open_w;
  assign ld_gpio_sel = (ldev_num == LDN_GPIO);
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_sel,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       cfg_open,
  input logic [7:0] cur_index,
  input logic [7:0] ldev_num,
  input logic       ld_wr_stb,
  input logic       ld_rd_stb
);
  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(bus_wr && !bus_sel && bus_wdata == 8'h87));

  p_close_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && bus_wr && !bus_sel && bus_wdata == 8'hAA) |=> !cfg_open);

  p_closed_reads_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> bus_rdata == 8'hFF);

  p_no_fwd_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wr_stb || ld_rd_stb) |-> cfg_open);

  p_index_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_open && bus_wr && !bus_sel) |=> $stable(cur_index));

  p_ldev_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_open && bus_wr && bus_sel && cur_index == 8'h07) |=> $stable(ldev_num));
endmodule

bind cfg_access_port cfgp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_sel   (bus_sel),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .cfg_open  (cfg_open),
  .cur_index (cur_index),
  .ldev_num  (ldev_num),
  .ld_wr_stb (ld_wr_stb),
  .ld_rd_stb (ld_rd_stb)
);

// File: tb/cfg_access_port_tb.sv
module cfg_access_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0, ld_rdata = '0;
  logic [7:0] bus_rdata, cur_index, ldev_num;
  logic cfg_open, ld_gpio_sel, ld_wr_stb, ld_rd_stb;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_access_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_open(cfg_open), .cur_index(cur_index), .ldev_num(ldev_num),
    .ld_gpio_sel(ld_gpio_sel), .ld_wr_stb(ld_wr_stb),
    .ld_rd_stb(ld_rd_stb), .ld_rdata(ld_rdata)
  );

  // Vector: [13] 1=read-check 0=write, [12] port select, [11:8] requirement, [7:0] byte
  localparam logic [13:0] VEC [20] = '{
    {1'b1, 1'b1, 4'd5, 8'hFF},  // R5 closed data read
    {1'b0, 1'b0, 4'd2, 8'h87},  // R2 first key
    {1'b1, 1'b0, 4'd5, 8'hFF},  // R5 half-open index read still FF
    {1'b0, 1'b0, 4'd2, 8'h87},  // R2 second key
    {1'b1, 1'b0, 4'd6, 8'h00},  // R6 index reads back
    {1'b0, 1'b0, 4'd8, 8'h20},
    {1'b1, 1'b1, 4'd8, 8'h0A},  // R8 device high
    {1'b0, 1'b0, 4'd8, 8'h21},
    {1'b1, 1'b1, 4'd8, 8'h5C},  // R8 device low
    {1'b0, 1'b0, 4'd8, 8'h22},
    {1'b1, 1'b1, 4'd8, 8'h03},  // R8 revision
    {1'b0, 1'b0, 4'd8, 8'h23},
    {1'b1, 1'b1, 4'd8, 8'h19},  // R8 vendor high
    {1'b0, 1'b0, 4'd8, 8'h24},
    {1'b1, 1'b1, 4'd8, 8'h34},  // R8 vendor low
    {1'b0, 1'b0, 4'd7, 8'h07},
    {1'b0, 1'b1, 4'd7, 8'h06},
    {1'b1, 1'b1, 4'd7, 8'h06},  // R7 device number reads back
    {1'b0, 1'b0, 4'd4, 8'hAA},
    {1'b1, 1'b1, 4'd4, 8'hFF}   // R4 closed again
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic sel, input logic [7:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = sel;
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 open", {7'd0, cfg_open}, 8'h00);
    check("R1 index", cur_index, 8'h00);
    check("R1 ldev", ldev_num, 8'h00);
    check("R1 gpio", {7'd0, ld_gpio_sel}, 8'h00);

    for (int i = 0; i < 20; i++) begin
      if (VEC[i][13])
        rd_chk($sformatf("R%0d vec%0d", VEC[i][11:8], i), VEC[i][12], VEC[i][7:0]);
      else
        wr(VEC[i][12], VEC[i][7:0]);
    end
    #1;
    check("R4 index kept on close", cur_index, 8'h07);
    check("R7 gpio flag", {7'd0, ld_gpio_sel}, 8'h01);

    // R5 closed: data write to device select ignored, index write ignored
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 8'h09;
    #1 check("R5 no wr strobe", {7'd0, ld_wr_stb}, 8'h00);
    @(negedge clk) bus_wr = 1'b0;
    wr(1'b0, 8'h40);
    #1;
    check("R5 ldev kept", ldev_num, 8'h06);
    check("R5 index kept", cur_index, 8'h07);

    // R3 broken key sequence restarts
    wr(1'b0, 8'h87); wr(1'b0, 8'h12); wr(1'b0, 8'h87);
    #1 check("R3 still closed", {7'd0, cfg_open}, 8'h00);
    rd_chk("R3 data read FF", 1'b1, 8'hFF);
    wr(1'b0, 8'h87);
    #1 check("R2 open after restart", {7'd0, cfg_open}, 8'h01);

    // R9 forwarding
    wr(1'b0, 8'h45);
    ld_rdata = 8'h5A;
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 8'h11;
    #1 check("R9 wr strobe", {7'd0, ld_wr_stb}, 8'h01);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1;
    #1 begin
      check("R9 rd strobe", {7'd0, ld_rd_stb}, 8'h01);
      check("R9 rd data", bus_rdata, 8'h5A);
    end
    @(negedge clk) bus_rd = 1'b0;
    wr(1'b0, 8'h10);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = 1'b1;
    #1 begin
      check("R9 local unused reads 0", bus_rdata, 8'h00);
      check("R9 no rd strobe local", {7'd0, ld_rd_stb}, 8'h00);
    end
    @(negedge clk) bus_rd = 1'b0;

    // R7 other device clears gpio flag
    wr(1'b0, 8'h07); wr(1'b1, 8'h03);
    #1 check("R7 gpio flag clear", {7'd0, ld_gpio_sel}, 8'h00);
    check("R7 ldev", ldev_num, 8'h03);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule